// File: doc/BRIEF.md
# Priority Flow Control Pause Frame Generator

This block builds a priority-based flow control pause frame and sends it as a byte stream with valid/ready handshaking into a MAC transmit path. It shares that path with normal frames. A trigger pulse requests a frame. The request is taken only while the transmitter enable is high. The pause frame goes out at once if no normal frame is in flight. Otherwise it waits for the last byte of the current normal frame, and the next normal frame is held back until the pause frame has left.

The frame carries these fields in order: the reserved multicast destination 01-80-C2-00-00-01, a source address supplied on a port, the MAC control type, the priority pause opcode, a 16-bit priority enable vector, and eight 16-bit quanta. Each quantum is chosen per priority. It is zero when that priority's mask bit is set. Otherwise it is the shared quantum, or, in per-priority mode, that priority's own value. The frame is then zero-padded to 60 bytes and closed with a 4-byte CRC-32 frame check sequence. When the last byte is accepted, a sticky interrupt flag is raised and a sent-frame counter increments.

All frame fields are captured when the frame is granted, so configuration changes during transmission do not corrupt the frame in flight.

Top module: `pfc_pause_gen`

## Requirements
- R1: After reset, tx_valid, pause_irq and pause_cnt are 0. With no pause work pending, the normal stream passes straight through: nrm_ready equals tx_ready.
- R2: Bytes 0-5 of a pause frame are 01 80 C2 00 00 01. Bytes 6-11 are src_addr, most significant byte first. Bytes 12-13 are 88 08 and bytes 14-15 are 01 01.
- R3: Byte 16 is 00 and byte 17 is pfc_cfg[7:0], the priority enable vector.
- R4: Bytes 18+2p and 19+2p carry the quantum of priority p (p = 0..7), high byte first. If pfc_cfg[8+p] is 1 the quantum is 0. Otherwise, with per_prio_mode low, it is the shared quantum.
- R5: With per_prio_mode high and pfc_cfg[8+p] low, the quantum of priority p is prio_quanta[16p+15:16p].
- R6: Bytes 34-59 are 00. The frame is exactly 64 bytes, and tx_last is high on byte 63 only.
- R7: Bytes 60-63 hold the inverted reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones) of bytes 0-59, least significant byte first.
- R8: A trigger while tx_en is low is ignored: no frame is sent and pause_cnt does not change.
- R9: A normal frame in progress is never interrupted. A pending pause frame is sent right after that frame's last byte, and a following normal frame waits until the pause frame ends.
- R10: Repeated triggers while a request is pending produce one frame. A trigger during a pause frame produces exactly one more frame after it.
- R11: When a pause frame's last byte is accepted, pause_irq is set and pause_cnt increments by one. pause_irq stays set until irq_clr.
- R12: While tx_ready is low during a pause frame, tx_valid stays high and tx_data holds its value.
- R13: The shared quantum resets to 0xFFFF and is loaded from quant_wdata when quant_wr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; triggers are taken only while high |
| pause_trig | input | 1 | One-cycle request for a pause frame |
| per_prio_mode | input | 1 | Selects per-priority quanta instead of the shared one |
| pfc_cfg | input | 16 | [7:0] priority enable vector, [15:8] zero-quantum mask |
| src_addr | input | 48 | Station source address |
| prio_quanta | input | 128 | Eight per-priority quanta, priority p at [16p+15:16p] |
| quant_wr | input | 1 | Write strobe for the shared quantum |
| quant_wdata | input | 16 | New shared quantum value |
| nrm_valid | input | 1 | Normal frame byte valid |
| nrm_data | input | 8 | Normal frame byte |
| nrm_last | input | 1 | Last byte of the normal frame |
| nrm_ready | output | 1 | Normal byte accepted |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Last byte of the output frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| pause_irq | output | 1 | Sticky pause-frame-sent flag |
| irq_clr | input | 1 | Clears pause_irq |
| pause_cnt | output | 16 | Count of pause frames sent |

## Verification
The bench drives a trigger in the middle of a normal frame. A design that grants at the wrong time would splice pause bytes into that frame, or let the next normal frame slip in ahead of the pause frame. It checks every byte of frames whose masks, modes and quanta differ, including the CRC. Swapped quantum order, a wrong shared or per-priority choice, or a stale CRC update would each show up as a byte mismatch. Downstream back-pressure is applied throughout one frame to expose any byte skipped or repeated during a stall. Bursts of triggers while a request is pending or a frame is in flight check that requests merge into exactly one extra frame, and that triggers with the transmitter disabled are dropped.

// File: rtl/pfcgen_pkg.sv
package pfcgen_pkg;

    localparam int PRIO_N    = 8;
    localparam int QW        = 16;
    localparam int FIX_BYTES = 18;
    localparam int HDR_BYTES = FIX_BYTES + PRIO_N * QW / 8;
    localparam int MIN_BYTES = 60;
    localparam int FCS_BYTES = 4;
    localparam int FRAME_N   = MIN_BYTES + FCS_BYTES;
    localparam int IDX_W     = $clog2(FRAME_N);

    localparam logic [47:0] PAUSE_DA   = 48'h0180C2000001;
    localparam logic [15:0] CTRL_TYPE  = 16'h8808;
    localparam logic [15:0] PFC_OPCODE = 16'h0101;
    localparam logic [31:0] CRC_RPOLY  = 32'hEDB88320;

    typedef logic [PRIO_N-1:0][QW-1:0] quanta_t;

    typedef struct packed {
        logic [47:0] sa;
        logic [7:0]  pev;
        quanta_t     q;
    } pfc_fields_t;

    typedef enum logic [1:0] {
        QSRC_SHARED,
        QSRC_OWN,
        QSRC_ZERO
    } qsrc_e;

    function automatic logic [HDR_BYTES*8-1:0] pack_header(pfc_fields_t f);
        logic [HDR_BYTES*8-1:0] h;
        h = '0;
        h[HDR_BYTES*8-1 -: FIX_BYTES*8] = {PAUSE_DA, f.sa, CTRL_TYPE, PFC_OPCODE, 8'h00, f.pev};
        for (int p = 0; p < PRIO_N; p++) begin
            h[(PRIO_N-1-p)*QW +: QW] = f.q[p];
        end
        return h;
    endfunction

    function automatic logic [31:0] crc_step(logic [31:0] c_in, logic [7:0] b);
        logic [31:0] c;
        c = c_in ^ {24'h0, b};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_RPOLY) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/pfc_quanta_sel.sv
module pfc_quanta_sel
    import pfcgen_pkg::*;
#(
    parameter int NPRIO = PRIO_N,
    parameter int QBITS = QW
) (
    input  logic [QBITS-1:0]       shared_q,
    input  logic [NPRIO*QBITS-1:0] own_q,
    input  logic [NPRIO-1:0]       zero_mask,
    input  logic                   own_mode,
    output logic [NPRIO-1:0][QBITS-1:0] q_out
);

    for (genvar p = 0; p < NPRIO; p++) begin : g_prio
        qsrc_e src;

        always_comb begin
            if (zero_mask[p])  src = QSRC_ZERO;
            else if (own_mode) src = QSRC_OWN;
            else               src = QSRC_SHARED;
        end

        always_comb begin
            case (src)
                QSRC_ZERO: q_out[p] = '0;
                QSRC_OWN:  q_out[p] = own_q[p*QBITS +: QBITS];
                default:   q_out[p] = shared_q;
            endcase
        end
    end

endmodule

// File: rtl/pfc_tx_arb.sv
module pfc_tx_arb (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic trig,
    input  logic nrm_valid,
    input  logic nrm_last,
    input  logic tx_ready,
    input  logic pause_busy,
    output logic grant,
    output logic nrm_ready
);

    logic pend;
    logic in_normal;
    logic nrm_take;

    assign grant     = pend && tx_en && !in_normal && !pause_busy;
    assign nrm_ready = tx_ready && !pause_busy && !grant;
    assign nrm_take  = nrm_valid && nrm_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            in_normal <= 1'b0;
        end else begin
            pend <= (pend && !grant) || (trig && tx_en);
            if (nrm_take) in_normal <= !nrm_last;
        end
    end

    assert_trig_dropped_R8: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !pend) |=> !pend);

    assert_grant_starts_frame_R9: assert property (@(posedge clk) disable iff (rst)
        grant |=> pause_busy);

    assert_no_split_R9: assert property (@(posedge clk) disable iff (rst)
        (in_normal && !nrm_take) |=> !pause_busy || $past(pause_busy));

endmodule

// File: rtl/pfc_frame_ser.sv
module pfc_frame_ser
    import pfcgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  pfc_fields_t fields,
    input  logic        out_ready,
    output logic        busy,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_N - 1);

    logic [HDR_BYTES*8-1:0] hdr_q;
    logic [IDX_W-1:0]       idx;
    logic [31:0]            crc_q;
    logic [31:0]            fcs;
    logic                   take;
    int                     pos;

    assign take     = busy && out_ready;
    assign out_last = busy && (idx == LAST_IDX);
    assign done     = take && (idx == LAST_IDX);
    assign fcs      = ~crc_q;

    always_comb begin
        pos = int'(idx);
        if (pos < HDR_BYTES)      out_data = hdr_q[(HDR_BYTES-1-pos)*8 +: 8];
        else if (pos < MIN_BYTES) out_data = 8'h00;
        else                      out_data = fcs[(pos-MIN_BYTES)*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            idx   <= '0;
            crc_q <= '1;
            hdr_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            idx   <= '0;
            crc_q <= '1;
            hdr_q <= pack_header(fields);
        end else if (take) begin
            if (pos < MIN_BYTES) crc_q <= crc_step(crc_q, out_data);
            if (done) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assert_hold_on_stall_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && !out_ready && !start) |=> busy && $stable(out_data));

    assert_start_idle_R10: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

endmodule

// File: rtl/pfc_pause_gen.sv
module pfc_pause_gen
    import pfcgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_en,
    input  logic               pause_trig,
    input  logic               per_prio_mode,
    input  logic [15:0]        pfc_cfg,
    input  logic [47:0]        src_addr,
    input  logic [127:0]       prio_quanta,
    input  logic               quant_wr,
    input  logic [15:0]        quant_wdata,
    input  logic               nrm_valid,
    input  logic [7:0]         nrm_data,
    input  logic               nrm_last,
    output logic               nrm_ready,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    output logic               tx_last,
    input  logic               tx_ready,
    output logic               pause_irq,
    input  logic               irq_clr,
    output logic [CNT_W-1:0]   pause_cnt
);

    localparam logic [QW-1:0] SHARED_RST = '1;

    logic [QW-1:0] shared_q;
    quanta_t       sel_q;
    pfc_fields_t   fields;
    logic          grant;
    logic          ser_busy;
    logic [7:0]    ser_data;
    logic          ser_last;
    logic          ser_done;

    always_ff @(posedge clk) begin
        if (rst)           shared_q <= SHARED_RST;
        else if (quant_wr) shared_q <= quant_wdata;
    end

    pfc_quanta_sel #(.NPRIO(PRIO_N), .QBITS(QW)) u_qsel (
        .shared_q  (shared_q),
        .own_q     (prio_quanta),
        .zero_mask (pfc_cfg[15:8]),
        .own_mode  (per_prio_mode),
        .q_out     (sel_q)
    );

    assign fields = '{sa: src_addr, pev: pfc_cfg[7:0], q: sel_q};

    pfc_tx_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .trig       (pause_trig),
        .nrm_valid  (nrm_valid),
        .nrm_last   (nrm_last),
        .tx_ready   (tx_ready),
        .pause_busy (ser_busy),
        .grant      (grant),
        .nrm_ready  (nrm_ready)
    );

    pfc_frame_ser u_ser (
        .clk       (clk),
        .rst       (rst),
        .start     (grant),
        .fields    (fields),
        .out_ready (tx_ready),
        .busy      (ser_busy),
        .out_data  (ser_data),
        .out_last  (ser_last),
        .done      (ser_done)
    );

    assign tx_valid = ser_busy || (!grant && nrm_valid);
    assign tx_data  = ser_busy ? ser_data : nrm_data;
    assign tx_last  = ser_busy ? ser_last : nrm_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            pause_irq <= 1'b0;
            pause_cnt <= '0;
        end else begin
            if (ser_done)     pause_irq <= 1'b1;
            else if (irq_clr) pause_irq <= 1'b0;
            if (ser_done)     pause_cnt <= pause_cnt + 1'b1;
        end
    end

    assert_cnt_with_irq_R11: assert property (@(posedge clk) disable iff (rst)
        (pause_cnt != $past(pause_cnt)) |-> pause_irq);

    assert_irq_after_frame_R11: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last && ser_busy) |=> pause_irq);

endmodule

// File: tb/pfc_pause_gen_test.sv
module pfc_pause_gen_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tx_en = 1'b0;
    logic         pause_trig = 1'b0;
    logic         per_prio_mode = 1'b0;
    logic [15:0]  pfc_cfg = '0;
    logic [47:0]  src_addr = 48'h02AB_CD12_3456;
    logic [127:0] prio_quanta = '0;
    logic         quant_wr = 1'b0;
    logic [15:0]  quant_wdata = '0;
    logic         nrm_valid = 1'b0;
    logic [7:0]   nrm_data = '0;
    logic         nrm_last = 1'b0;
    logic         nrm_ready;
    logic         tx_valid;
    logic [7:0]   tx_data;
    logic         tx_last;
    logic         tx_ready = 1'b1;
    logic         pause_irq;
    logic         irq_clr = 1'b0;
    logic [15:0]  pause_cnt;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] log_d [0:255];
    logic       log_l [0:255];
    int         log_n = 0;
    logic [7:0] exp_f [0:63];
    logic [15:0] shared_model = 16'hFFFF;

    always #10 clk = ~clk;

    pfc_pause_gen uut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .pause_trig(pause_trig),
        .per_prio_mode(per_prio_mode), .pfc_cfg(pfc_cfg), .src_addr(src_addr),
        .prio_quanta(prio_quanta), .quant_wr(quant_wr), .quant_wdata(quant_wdata),
        .nrm_valid(nrm_valid), .nrm_data(nrm_data), .nrm_last(nrm_last),
        .nrm_ready(nrm_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .pause_irq(pause_irq),
        .irq_clr(irq_clr), .pause_cnt(pause_cnt)
    );

    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready && log_n < 256) begin
            log_d[log_n] = tx_data;
            log_l[log_n] = tx_last;
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_trig();
        pause_trig = 1'b1;
        tick(1);
        pause_trig = 1'b0;
    endtask

    task automatic wait_log(input int n, input int limit);
        for (int c = 0; c < limit && log_n < n; c++) tick(1);
    endtask

    function automatic logic [31:0] ref_crc(input int nbytes);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < nbytes; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ exp_f[i][b];
                c = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return ~c;
    endfunction

    task automatic build_expected();
        logic [31:0] f;
        logic [47:0] da;
        da = 48'h0180_C200_0001;
        for (int i = 0; i < 64; i++) exp_f[i] = 8'h00;
        for (int i = 0; i < 6; i++) begin
            exp_f[i]     = da[(5-i)*8 +: 8];
            exp_f[6+i]   = src_addr[(5-i)*8 +: 8];
        end
        exp_f[12] = 8'h88; exp_f[13] = 8'h08;
        exp_f[14] = 8'h01; exp_f[15] = 8'h01;
        exp_f[16] = 8'h00; exp_f[17] = pfc_cfg[7:0];
        for (int p = 0; p < 8; p++) begin
            logic [15:0] q;
            if (pfc_cfg[8+p])       q = 16'h0000;
            else if (per_prio_mode) q = prio_quanta[p*16 +: 16];
            else                    q = shared_model;
            exp_f[18+2*p] = q[15:8];
            exp_f[19+2*p] = q[7:0];
        end
        f = ref_crc(60);
        for (int k = 0; k < 4; k++) exp_f[60+k] = f[k*8 +: 8];
    endtask

    task automatic cmp_frame(input int base, input string tag);
        int bad;
        int first;
        bad = 0; first = -1;
        build_expected();
        for (int i = 0; i < 64; i++) begin
            if (log_d[base+i] !== exp_f[i] || log_l[base+i] !== (i == 63)) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) first = 0;
        chk(bad == 0, $sformatf("%s frame byte %0d", tag, first),
            {log_l[base+first], log_d[base+first]}, {(first == 63), exp_f[first]});
    endtask

    task automatic send_normal(input int n, input logic [7:0] b0);
        for (int k = 0; k < n; k++) begin
            nrm_valid = 1'b1;
            nrm_data  = b0 + 8'(k);
            nrm_last  = (k == n - 1);
            @(negedge clk);
            while (!nrm_ready) @(negedge clk);
            tick(1);
        end
        nrm_valid = 1'b0;
        nrm_last  = 1'b0;
    endtask

    task automatic t_reset();
        chk(tx_valid == 1'b0, "R1 tx_valid after reset", tx_valid, 0);
        chk(pause_irq == 1'b0, "R1 pause_irq after reset", pause_irq, 0);
        chk(pause_cnt == 16'd0, "R1 pause_cnt after reset", pause_cnt, 0);
        tx_ready = 1'b0;
        #1;
        chk(nrm_ready == 1'b0, "R1 nrm_ready follows tx_ready low", nrm_ready, 0);
        tx_ready = 1'b1;
        #1;
        chk(nrm_ready == 1'b1, "R1 nrm_ready follows tx_ready high", nrm_ready, 1);
    endtask

    task automatic t_basic();
        tx_en = 1'b1;
        pfc_cfg = 16'h24A5;
        log_n = 0;
        pulse_trig();
        wait_log(64, 300);
        tick(2);
        chk(log_n == 64, "R6 frame length", log_n, 64);
        cmp_frame(0, "R2 R3 R4 R6 R7 R13 default shared");
        chk(pause_irq == 1'b1, "R11 irq set after frame", pause_irq, 1);
        chk(pause_cnt == 16'd1, "R11 count after frame", pause_cnt, 1);
        tick(3);
        chk(pause_irq == 1'b1, "R11 irq sticky", pause_irq, 1);
        irq_clr = 1'b1;
        tick(1);
        irq_clr = 1'b0;
        chk(pause_irq == 1'b0, "R11 irq cleared", pause_irq, 0);
    endtask

    task automatic t_load_quant();
        quant_wdata = 16'h1234;
        quant_wr = 1'b1;
        tick(1);
        quant_wr = 1'b0;
        shared_model = 16'h1234;
        pfc_cfg = 16'h003C;
        log_n = 0;
        pulse_trig();
        wait_log(64, 300);
        tick(2);
        cmp_frame(0, "R13 R4 loaded shared quantum");
    endtask

    task automatic t_own_mode();
        for (int p = 0; p < 8; p++) prio_quanta[p*16 +: 16] = 16'h1100 + 16'(p * 16'h0203);
        per_prio_mode = 1'b1;
        pfc_cfg = 16'h81FF;
        log_n = 0;
        pulse_trig();
        wait_log(64, 300);
        tick(2);
        cmp_frame(0, "R5 per-priority quanta");
        per_prio_mode = 1'b0;
    endtask

    task automatic t_stall();
        pfc_cfg = 16'h1001;
        src_addr = 48'hA1B2_C3D4_E5F6;
        log_n = 0;
        fork
            pulse_trig();
            for (int c = 0; c < 250; c++) begin
                tx_ready = (c % 3) != 1;
                tick(1);
            end
        join
        tx_ready = 1'b1;
        wait_log(64, 300);
        tick(2);
        chk(log_n == 64, "R12 length under back-pressure", log_n, 64);
        cmp_frame(0, "R12 frame under back-pressure");
    endtask

    task automatic t_disabled();
        logic [15:0] c0;
        c0 = pause_cnt;
        tx_en = 1'b0;
        log_n = 0;
        pulse_trig();
        tick(2);
        tx_en = 1'b1;
        tick(100);
        chk(log_n == 0, "R8 no frame when disabled", log_n, 0);
        chk(pause_cnt == c0, "R8 count unchanged", pause_cnt, c0);
    endtask

    task automatic t_normal();
        int ok;
        pfc_cfg = 16'h0000;
        log_n = 0;
        fork
            begin
                send_normal(10, 8'hA0);
                send_normal(3, 8'hC0);
            end
            begin
                tick(3);
                pulse_trig();
            end
        join
        wait_log(77, 400);
        tick(2);
        chk(log_n == 77, "R9 total bytes", log_n, 77);
        ok = 1;
        for (int k = 0; k < 10; k++)
            if (log_d[k] !== 8'hA0 + 8'(k) || log_l[k] !== (k == 9)) ok = 0;
        chk(ok == 1, "R9 first normal frame intact", ok, 1);
        cmp_frame(10, "R9 pause between frames");
        ok = 1;
        for (int k = 0; k < 3; k++)
            if (log_d[74+k] !== 8'hC0 + 8'(k) || log_l[74+k] !== (k == 2)) ok = 0;
        chk(ok == 1, "R9 next normal frame after pause", ok, 1);
    endtask

    task automatic t_dup();
        logic [15:0] c0;
        c0 = pause_cnt;
        log_n = 0;
        fork
            send_normal(6, 8'h50);
            begin
                tick(2); pulse_trig();
                tick(1); pulse_trig();
            end
        join
        wait_log(70, 300);
        tick(120);
        chk(log_n == 70, "R10 merged pending triggers", log_n, 70);
        chk(pause_cnt == c0 + 16'd1, "R10 one frame counted", pause_cnt, c0 + 16'd1);
        log_n = 0;
        pulse_trig();
        tick(10);
        pulse_trig();
        tick(3);
        pulse_trig();
        wait_log(128, 400);
        tick(120);
        chk(log_n == 128, "R10 one extra frame after in-flight trigger", log_n, 128);
        cmp_frame(64, "R10 second frame content");
        chk(pause_cnt == c0 + 16'd3, "R10 count after two frames", pause_cnt, c0 + 16'd3);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                failures++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_basic();
        t_load_quant();
        t_own_mode();
        t_stall();
        t_disabled();
        t_normal();
        t_dup();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule